// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This core runs one instruction per clock. On every rising edge it takes the word that the external instruction memory returns for the current program counter. It decodes that word, reads up to two operands from a 32-entry register file and computes a result in the ALU. It then writes a register or stores to data memory, and loads the next program counter. Both memories are outside the block and are read combinationally: the core drives an address and the word comes back in the same cycle.

Control flow can take one of five paths. The first is the sequential address. The second is a branch target relative to the PC, used when the first operand is zero or nonzero. The third is a jump to an address held in a register. The last two are two fixed vectors: one for an undefined opcode and one for an interrupt request. Both vector paths save the return address in a dedicated exception-pointer register, using a write-address select that overrides the destination field. The interrupt input is sampled at every edge, and each edge is an instruction boundary. When the request is high, the current instruction is discarded in favour of interrupt entry.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 and every register becomes zero. `dmem_we` stays low for as long as `rst_n` is low.
- R2: Instruction fields are: opcode in bits 31:26, destination `rc` in bits 25:21, first source `ra` in bits 20:16, second source `rb` in bits 15:11, and a 16-bit constant in bits 15:0.
- R3: For an opcode of binary 10ffff (register form, second operand from `rb`) or 11ffff (constant form), the function code ffff writes `rc` as follows: 0 add, 1 subtract (ra-rb), 2 and, 3 or, 4 xor, 5 equal (1/0), 6 signed less-than (1/0), 7 shift left, 8 logical shift right, 9 arithmetic shift right. The shift amount is bits 4:0 of the second operand.
- R4: The 16-bit constant is sign-extended to 32 bits wherever it is used: as an ALU operand, as a memory offset and as a branch offset.
- R5: Load (opcode 0x18) writes `rc` with the data word at address `ra`+constant. Store (0x19) writes the value of `rc` to address `ra`+constant and writes no register.
- R6: BEQ (0x1C) and BNE (0x1D) write PC+4 into `rc`. The next PC is PC+4+4*constant when `ra` is zero (BEQ) or nonzero (BNE). Otherwise the next PC is PC+4.
- R7: Jump (0x1B) writes PC+4 into `rc` and continues at the value of `ra` with bits 1:0 cleared.
- R8: Register 31 always reads as zero, and writes to it have no effect.
- R9: Any other opcode is illegal, including the 10/11 forms with function codes 10 to 15. An illegal opcode performs no store and does not write `rc`. It writes PC+4 into register 30 and sets the next PC to 0x4.
- R10: When `irq` is high at an edge, the fetched instruction has no effect: no store and no `rc` write. Register 30 receives PC+4 and the next PC is 0x8. This takes precedence over R9.
- R11: Every other instruction (ALU, load, store) continues at PC+4, and the PC is always a multiple of four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Interrupt request, level sampled at each edge |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |
| dmem_we | output | 1 | Store strobe; the word is written at the rising edge |

## Verification
A wrong PC shows on `imem_addr` in the very next cycle, so the vector and sequencing properties catch next-PC errors at once. A corrupted register, a bad operand select or a wrong write-back source cannot be seen until a later store puts that register on `dmem_wdata`. The directed programs therefore end each scenario by storing every register they touched, and they read the results from the modelled data memory. Store suppression under an interrupt or an illegal opcode is seen through sentinel words that must stay unchanged. The value saved in register 30 is seen through the handler's store.

// File: rtl/core_pkg.sv
// Shared types and encodings for the single-cycle core.
// Assumes a fixed 32-bit instruction word and 5-bit register fields.
package core_pkg;
    localparam int ILEN  = 32;
    localparam int FLD_W = 5;
    localparam int NREG  = 1 << FLD_W;

    localparam logic [5:0] OP_LOAD  = 6'h18;
    localparam logic [5:0] OP_STORE = 6'h19;
    localparam logic [5:0] OP_JUMP  = 6'h1B;
    localparam logic [5:0] OP_BEQ   = 6'h1C;
    localparam logic [5:0] OP_BNE   = 6'h1D;
    localparam logic [3:0] FN_LAST  = 4'd9;

    typedef enum logic [3:0] {
        FN_ADD = 4'd0, FN_SUB = 4'd1, FN_AND = 4'd2, FN_OR  = 4'd3, FN_XOR = 4'd4,
        FN_CEQ = 4'd5, FN_CLT = 4'd6, FN_SHL = 4'd7, FN_SHR = 4'd8, FN_SRA = 4'd9
    } alu_fn_e;

    typedef enum logic [2:0] {
        NPC_SEQ, NPC_BRANCH, NPC_JUMP, NPC_ILLEGAL, NPC_IRQ
    } npc_sel_e;

    typedef enum logic [1:0] {
        WB_LINK, WB_ALU, WB_MEM
    } wb_sel_e;

    typedef struct packed {
        logic     opb_const;   // second ALU operand is the constant
        logic     rd2_from_rc; // second read port addresses rc (stores)
        wb_sel_e  wb_sel;
        logic     wa_xptr;     // write the exception-pointer register
        logic     rf_we;
        logic     mem_we;
        alu_fn_e  alu_fn;
        npc_sel_e npc_sel;
    } ctrl_t;
endpackage

// File: rtl/core_regfile.sv
// Register file: two combinational read ports, one write port.
// The highest register reads as zero and is never written.
module core_regfile #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra1,
    input  logic [AW-1:0]   ra2,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd,
    input  logic            we,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] ZREG = AW'(DEPTH - 1);

    logic [XLEN-1:0] regs [DEPTH];

    // Clear all entries on reset, otherwise perform the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && wa != ZREG) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == ZREG) ? '0 : regs[ra1];
    assign rd2 = (ra2 == ZREG) ? '0 : regs[ra2];
endmodule

// File: rtl/core_alu.sv
// Combinational ALU. Shift amount is the low log2(XLEN) bits of b.
module core_alu
    import core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] y
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    // Select the operation result.
    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_CEQ:  y = {{(XLEN-1){1'b0}}, a == b};
            FN_CLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
            FN_SHL:  y = a << shamt;
            FN_SHR:  y = a >> shamt;
            FN_SRA:  y = $unsigned($signed(a) >>> shamt);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/core_ctrl.sv
// Decode and control: turns the opcode, the interrupt request and the
// zero flag into select signals. The interrupt overrides everything.
module core_ctrl
    import core_pkg::*;
(
    input  logic [5:0] op,
    input  logic       irq,
    input  logic       ra_zero,
    output ctrl_t      ctl
);
    logic illegal;

    // Decode the opcode, then apply the illegal and interrupt overrides.
    always_comb begin
        ctl         = '0;
        ctl.wb_sel  = WB_ALU;
        ctl.alu_fn  = FN_ADD;
        ctl.npc_sel = NPC_SEQ;
        illegal     = 1'b0;
        if (op[5]) begin
            if (op[3:0] <= FN_LAST) begin
                ctl.rf_we     = 1'b1;
                ctl.opb_const = op[4];
                ctl.alu_fn    = alu_fn_e'(op[3:0]);
            end else begin
                illegal = 1'b1;
            end
        end else begin
            case (op)
                OP_LOAD: begin
                    ctl.rf_we     = 1'b1;
                    ctl.opb_const = 1'b1;
                    ctl.wb_sel    = WB_MEM;
                end
                OP_STORE: begin
                    ctl.mem_we      = 1'b1;
                    ctl.opb_const   = 1'b1;
                    ctl.rd2_from_rc = 1'b1;
                end
                OP_JUMP: begin
                    ctl.rf_we   = 1'b1;
                    ctl.wb_sel  = WB_LINK;
                    ctl.npc_sel = NPC_JUMP;
                end
                OP_BEQ, OP_BNE: begin
                    ctl.rf_we   = 1'b1;
                    ctl.wb_sel  = WB_LINK;
                    ctl.npc_sel = (ra_zero == (op == OP_BEQ)) ? NPC_BRANCH : NPC_SEQ;
                end
                default: illegal = 1'b1;
            endcase
        end
        if (illegal || irq) begin
            ctl.mem_we  = 1'b0;
            ctl.rf_we   = 1'b1;
            ctl.wa_xptr = 1'b1;
            ctl.wb_sel  = WB_LINK;
            ctl.npc_sel = irq ? NPC_IRQ : NPC_ILLEGAL;
        end
    end
endmodule

// File: rtl/sc_core.sv
// Single-cycle processor core top. Assumes instruction and data memories
// that answer combinationally within the same cycle.
module sc_core
    import core_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter logic [XLEN-1:0] ILL_VEC  = XLEN'(4),
    parameter logic [XLEN-1:0] IRQ_VEC  = XLEN'(8),
    parameter int              XP_REG   = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq,
    output logic [XLEN-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            dmem_we
);
    localparam logic [XLEN-1:0]  STEP  = XLEN'(4);
    localparam logic [FLD_W-1:0] XP_WA = FLD_W'(XP_REG);

    logic [XLEN-1:0]  pc, pc_inc, pc_nxt, br_tgt, jmp_tgt, konst;
    logic [XLEN-1:0]  rd1, rd2, opb, alu_y, wb_data;
    logic [FLD_W-1:0] f_rc, f_ra, f_rb, rd2_addr, wr_addr;
    ctrl_t            ctl;

    assign f_rc     = imem_rdata[25:21];
    assign f_ra     = imem_rdata[20:16];
    assign f_rb     = imem_rdata[15:11];
    assign konst    = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};
    assign pc_inc   = pc + STEP;
    assign br_tgt   = pc_inc + (konst << 2);
    assign jmp_tgt  = {rd1[XLEN-1:2], 2'b00};
    assign rd2_addr = ctl.rd2_from_rc ? f_rc : f_rb;
    assign wr_addr  = ctl.wa_xptr ? XP_WA : f_rc;
    assign opb      = ctl.opb_const ? konst : rd2;

    core_ctrl u_ctrl (
        .op      (imem_rdata[31:26]),
        .irq     (irq),
        .ra_zero (rd1 == '0),
        .ctl     (ctl)
    );

    core_regfile #(.XLEN(XLEN), .AW(FLD_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (f_ra),
        .ra2   (rd2_addr),
        .wa    (wr_addr),
        .wd    (wb_data),
        .we    (ctl.rf_we),
        .rd1   (rd1),
        .rd2   (rd2)
    );

    core_alu #(.XLEN(XLEN)) u_alu (
        .a  (rd1),
        .b  (opb),
        .fn (ctl.alu_fn),
        .y  (alu_y)
    );

    // Write-back source select.
    always_comb begin
        case (ctl.wb_sel)
            WB_LINK: wb_data = pc_inc;
            WB_MEM:  wb_data = dmem_rdata;
            default: wb_data = alu_y;
        endcase
    end

    // Five-way next-PC select.
    always_comb begin
        case (ctl.npc_sel)
            NPC_BRANCH:  pc_nxt = br_tgt;
            NPC_JUMP:    pc_nxt = jmp_tgt;
            NPC_ILLEGAL: pc_nxt = ILL_VEC;
            NPC_IRQ:     pc_nxt = IRQ_VEC;
            default:     pc_nxt = pc_inc;
        endcase
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_PC;
        else        pc <= pc_nxt;
    end

    assign imem_addr  = pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rd2;
    assign dmem_we    = ctl.mem_we & rst_n;
endmodule

// File: rtl/sc_core_chk.sv
// Port-level properties of sc_core, attached with bind below.
module sc_core_chk #(
    parameter logic [31:0] ILL_VEC = 32'h4,
    parameter logic [31:0] IRQ_VEC = 32'h8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_rdata,
    input logic        dmem_we
);
    logic [5:0] op;
    logic       plain, legal;
    assign op    = imem_rdata[31:26];
    assign plain = (op[5] && op[3:0] <= 4'd9) || op == 6'h18 || op == 6'h19;
    assign legal = plain || op == 6'h1B || op == 6'h1C || op == 6'h1D;

    p_reset_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> imem_addr == 32'h0);
    p_pc_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[1:0] == 2'b00);
    p_seq_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && plain) |=> imem_addr == $past(imem_addr) + 32'd4);
    p_illegal_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !legal) |=> imem_addr == ILL_VEC);
    p_illegal_nostore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |-> !dmem_we);
    p_irq_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> imem_addr == IRQ_VEC);
    p_irq_nostore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !dmem_we);
endmodule

bind sc_core sc_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we)
);

// File: tb/sim_sc_core.sv
// Directed bench: each task loads a small program, runs it and checks
// the words the program stores into the modelled data memory.
module sim_sc_core;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SENT = 32'hDEADBEEF;
    localparam logic [5:0] LD = 6'h18, ST = 6'h19, JMP = 6'h1B, BEQ = 6'h1C, BNE = 6'h1D;
    localparam logic [5:0] ADD = 6'h20, SUB = 6'h21, AND_ = 6'h22, OR_ = 6'h23, XOR_ = 6'h24;
    localparam logic [5:0] CEQ = 6'h25, CLT = 6'h26, SHL = 6'h27;
    localparam logic [5:0] ADDC = 6'h30, SHLC = 6'h37, SHRC = 6'h38, SRAC = 6'h39;

    logic        clk = 1'b0, rst_n = 1'b0, irq = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int          n_checks = 0, n_fail = 0, wp = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sc_core u0 (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .dmem_we(dmem_we)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] rr(input logic [5:0] op, input int rc, input int ra, input int rb);
        return {op, 5'(rc), 5'(ra), 5'(rb), 11'b0};
    endfunction
    function automatic logic [31:0] ci(input logic [5:0] op, input int rc, input int ra, input int c);
        return {op, 5'(rc), 5'(ra), 16'(c)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Fill memories: self-loops everywhere, vectors at 0/4/8, handlers at 0xC0/0xE0.
    task automatic clear_mem;
        for (int i = 0; i < 64; i++) begin
            imem[i] = ci(BEQ, 31, 31, -1);
            dmem[i] = SENT;
        end
        imem[0]  = ci(BEQ, 31, 31, 3);
        imem[1]  = ci(BEQ, 31, 31, 46);
        imem[2]  = ci(BEQ, 31, 31, 53);
        imem[48] = ci(ST, 30, 31, 'h78);
        imem[56] = ci(ST, 30, 31, 'h7C);
        wp = 4;
    endtask

    task automatic emit(input logic [31:0] w);
        imem[wp] = w;
        wp++;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        irq   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        clear_mem();
        imem[0] = ci(ST, 31, 31, 'h80);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 no store in reset", {31'b0, dmem_we}, 32'h0);
        check("R1 word untouched in reset", dmem[32], SENT);
        check("R1 pc at reset", imem_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 r31 stored as zero", dmem[32], 32'h0);
        check("R11 sequential pc", imem_addr, 32'h4);
    endtask

    task automatic t_alu;
        clear_mem();
        emit(ci(ADDC, 1, 31, 5));
        emit(ci(ADDC, 2, 31, -3));
        emit(rr(ADD, 3, 1, 2));
        emit(rr(SUB, 4, 1, 2));
        emit(rr(AND_, 5, 1, 2));
        emit(rr(OR_, 6, 1, 2));
        emit(rr(XOR_, 7, 1, 2));
        emit(rr(CLT, 8, 2, 1));
        emit(rr(CEQ, 9, 1, 1));
        emit(ci(SHLC, 10, 1, 4));
        emit(ci(SHRC, 11, 2, 28));
        emit(ci(SRAC, 12, 2, 1));
        emit(rr(CEQ, 13, 1, 2));
        emit(rr(SHL, 14, 1, 1));
        for (int r = 2; r <= 15; r++) emit(ci(ST, r, 31, 'h80 + 4 * (r - 2)));
        do_reset();
        repeat (40) @(negedge clk);
        check("R4 negative constant", dmem[32], 32'hFFFFFFFD);
        check("R3 add", dmem[33], 32'h2);
        check("R3 sub", dmem[34], 32'h8);
        check("R3 and", dmem[35], 32'h5);
        check("R3 or", dmem[36], 32'hFFFFFFFD);
        check("R3 xor", dmem[37], 32'hFFFFFFF8);
        check("R3 signed less-than", dmem[38], 32'h1);
        check("R3 equal true", dmem[39], 32'h1);
        check("R3 shift left const", dmem[40], 32'h50);
        check("R3 logical shift right", dmem[41], 32'hF);
        check("R3 arithmetic shift right", dmem[42], 32'hFFFFFFFE);
        check("R3 equal false", dmem[43], 32'h0);
        check("R2 register-form shift uses rb", dmem[44], 32'hA0);
        check("R1 untouched register is zero", dmem[45], 32'h0);
    endtask

    task automatic t_ldst;
        clear_mem();
        dmem[40] = 32'hCAFEF00D;
        emit(ci(ADDC, 1, 31, 'h1234));
        emit(ci(ST, 1, 31, 'h80));
        emit(ci(LD, 2, 31, 'h80));
        emit(ci(ADDC, 3, 31, 'h40));
        emit(ci(ST, 2, 3, 'h44));
        emit(ci(ADDC, 31, 31, 7));
        emit(ci(ST, 31, 31, 'h88));
        emit(ci(LD, 5, 31, 'hA0));
        emit(ci(ST, 5, 31, 'h8C));
        emit(ci(ADDC, 6, 31, 'h98));
        emit(ci(ST, 1, 6, -8));
        do_reset();
        repeat (20) @(negedge clk);
        check("R5 store data", dmem[32], 32'h1234);
        check("R5 load then store with base", dmem[33], 32'h1234);
        check("R8 write to r31 ignored", dmem[34], 32'h0);
        check("R5 load of preset word", dmem[35], 32'hCAFEF00D);
        check("R4 negative store offset", dmem[36], 32'h1234);
    endtask

    task automatic t_branch;
        clear_mem();
        emit(ci(ADDC, 1, 31, 0));      // 0x10
        emit(ci(BEQ, 2, 1, 1));        // 0x14 taken -> 0x1C
        emit(ci(ADDC, 3, 31, 'h55));   // 0x18 skipped
        emit(ci(BNE, 4, 1, 1));        // 0x1C not taken
        emit(ci(ADDC, 5, 31, 'h77));   // 0x20
        emit(ci(ADDC, 6, 31, 'h37));   // 0x24 jump target, low bits cleared
        emit(rr(JMP, 7, 6, 0));        // 0x28 -> 0x34
        emit(ci(ADDC, 8, 31, 'h11));   // 0x2C skipped
        emit(ci(ADDC, 8, 31, 'h12));   // 0x30 skipped
        emit(ci(ADDC, 9, 31, 1));      // 0x34
        emit(ci(BNE, 10, 9, 1));       // 0x38 taken -> 0x40
        emit(ci(ADDC, 11, 31, 9));     // 0x3C skipped
        emit(ci(ST, 2, 31, 'h80));     // 0x40
        emit(ci(ST, 3, 31, 'h84));
        emit(ci(ST, 4, 31, 'h88));
        emit(ci(ST, 5, 31, 'h8C));
        emit(ci(ST, 7, 31, 'h90));
        emit(ci(ST, 8, 31, 'h94));
        emit(ci(ST, 10, 31, 'h98));
        emit(ci(ST, 11, 31, 'h9C));
        do_reset();
        repeat (30) @(negedge clk);
        check("R6 beq link", dmem[32], 32'h18);
        check("R6 beq taken skips", dmem[33], 32'h0);
        check("R6 bne not-taken link", dmem[34], 32'h20);
        check("R6 bne not taken falls through", dmem[35], 32'h77);
        check("R7 jump link", dmem[36], 32'h2C);
        check("R7 jump skips", dmem[37], 32'h0);
        check("R6 bne taken link", dmem[38], 32'h3C);
        check("R6 bne taken skips", dmem[39], 32'h0);
    endtask

    task automatic t_illegal(input logic [31:0] bad);
        clear_mem();
        emit(ci(ADDC, 1, 31, 1));      // 0x10
        emit(bad);                     // 0x14
        emit(ci(ST, 1, 31, 'h80));     // 0x18 must not run
        do_reset();
        repeat (12) @(negedge clk);
        check("R9 r30 gets pc+4", dmem[30], 32'h18);
        check("R9 next instruction not run", dmem[32], SENT);
        check("R9 irq handler not entered", dmem[31], SENT);
        check("R9 reached illegal handler", imem_addr, 32'hC4);
    endtask

    task automatic t_irq(input logic [31:0] w);
        clear_mem();
        emit(ci(ADDC, 1, 31, 'h42));   // 0x10
        emit(w);                       // 0x14 replaced by interrupt entry
        emit(ci(ST, 1, 31, 'h84));     // 0x18 must not run
        do_reset();
        while (imem_addr !== 32'h14) @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check("R10 vector after irq", imem_addr, 32'h8);
        repeat (10) @(negedge clk);
        check("R10 instruction discarded", dmem[32], SENT);
        check("R10 r30 gets pc+4", dmem[31], 32'h18);
        check("R10 precedence over illegal", dmem[30], SENT);
        check("R10 no return to program", dmem[33], SENT);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_alu();
        t_ldst();
        t_branch();
        t_illegal(32'h0);
        t_illegal(rr(6'h2A, 1, 1, 1));
        t_illegal(ci(6'h1A, 1, 31, 0));
        t_irq(ci(ST, 1, 31, 'h80));
        t_irq(32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule